// File: doc/BRIEF.md
# Parking Occupancy Controller

This block tracks how many vehicles are inside a parking facility and says when it is full. Two barrier handlers talk to it. One raises `enter_req` when a vehicle wants in, and the other raises `exit_req` when a vehicle wants out. Each handler keeps its request high until the block answers with a one-cycle `enter_done` or `exit_done` pulse, and then drops it. While the facility is full, `lot_full` is lit and entry requests are left waiting.

The block has two parts. The datapath holds one occupancy register with a load enable. A two-way operand select feeds either the constant one or the capacity constant into a single ripple adder/subtractor. Subtraction inverts the operand and forces a carry into the lowest bit. The datapath also has a zero flag on the adder result and a borrow flag. A six-state sequencer drives the load enable, the operand select and the add/subtract line, and reads back the two flags. The same adder does both the counting and the test against capacity.

The occupancy register has no clear. While the reset input is high, and after it drops, the sequencer walks the count down by one per cycle until it reaches zero, and then goes to the waiting state. The capacity is a parameter, and the counter width is derived from it as `$clog2(CAPACITY+1)`.

Top module: `lot_occ_ctrl`

## Requirements
- R1: In the waiting state, a request sampled at a clock edge produces its done pulse in the next cycle. The done pulse lasts exactly one cycle. `occupancy` changes by one (up for an entry, down for an exit) at the edge that ends the done pulse.
- R2: When `enter_req` and `exit_req` are both high in the waiting state, the exit is served and the entry is not.
- R3: After each entry the sequencer spends one cycle comparing the count with CAPACITY. `lot_full` rises two cycles after the `enter_done` cycle exactly when `occupancy` equals CAPACITY, and `lot_full` is high only at that count.
- R4: While `lot_full` is high, `enter_req` has no effect: no `enter_done` pulse, `occupancy` unchanged, and `lot_full` stays lit.
- R5: An exit request while full gives an `exit_done` pulse in the next cycle. `lot_full` is low in that same cycle, and `occupancy` drops by one at the following edge.
- R6: While `rst` is high, `enter_done` and `exit_done` are low and `lot_full` is low from the first edge on. The sequencer is forced into the step-down state.
- R7: In the step-down state, a nonzero `occupancy` falls by one at each edge. When it reaches zero the sequencer returns to waiting at that same edge, so a count of T clears in T cycles. The unused state codes 011 and 110 also lead to the step-down state at the next edge.
- R8: In the step-down state a count of zero never wraps. It stays at zero, and the sequencer leaves the state after one cycle.
- R9: With no request pending in the waiting, compare or full state, `occupancy` holds its value and no done pulse appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset request; forces the step-down sequence |
| enter_req | input | 1 | Entry request level from the entry barrier handler |
| exit_req | input | 1 | Exit request level from the exit barrier handler |
| enter_done | output | 1 | One-cycle pulse: one entry has been counted |
| exit_done | output | 1 | One-cycle pulse: one exit has been counted |
| lot_full | output | 1 | Full indicator; high while the count equals CAPACITY |
| occupancy | output | CNT_W | Current vehicle count |

## Verification
Single entries and exits separated by idle gaps check the step size and the latency of the done pulse. Simultaneous requests show which side wins. Filling the facility to its capacity, then holding an entry request while full, tells the compare path apart from the ordinary waiting path. A reset that starts from a nonzero count measures the length of the step-down. A reset that starts from zero separates a correct stop from a wrap to all ones.

// File: rtl/lot_occ_pkg.sv
package lot_occ_pkg;

   // Sequencer state codes; the values are fixed by the design
   typedef enum logic [2:0] {
      ST_IDLE  = 3'b000,
      ST_CHECK = 3'b001,
      ST_FULL  = 3'b010,
      ST_DECR  = 3'b100,
      ST_CLEAR = 3'b101,
      ST_INCR  = 3'b111
   } occ_state_e;

   // Datapath control word produced by the sequencer
   typedef struct packed {
      logic load;      // write the adder result into the count register
      logic pick_cap;  // operand select: 1 = capacity constant, 0 = constant one
      logic subtract;  // 1 = count minus operand, 0 = count plus operand
   } occ_ctrl_t;

endpackage

// File: rtl/lot_occ_addsub.sv
module lot_occ_addsub #(
   parameter int WIDTH = 3
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   logic [WIDTH:0]   carry;
   logic [WIDTH-1:0] b_eff;

   // subtract: invert the operand and inject a carry at the lowest bit
   assign carry[0] = sub;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign b_eff[i]   = b[i] ^ sub;
      assign sum[i]     = a[i] ^ b_eff[i] ^ carry[i];
      assign carry[i+1] = (a[i] & b_eff[i]) | (carry[i] & (a[i] ^ b_eff[i]));
   end

   assign cout = carry[WIDTH];

endmodule

// File: rtl/lot_occ_datapath.sv
module lot_occ_datapath #(
   parameter int CAPACITY = 6,
   parameter int CNT_W    = 3
) (
   input  logic                  clk,
   input  lot_occ_pkg::occ_ctrl_t ctrl,
   output logic [CNT_W-1:0]      total,
   output logic                  res_zero,
   output logic                  res_borrow
);

   localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);
   localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

   if ((1 << CNT_W) <= CAPACITY) begin : g_width_bad
      $error("lot_occ_datapath: CNT_W too narrow for CAPACITY");
   end

   logic [CNT_W-1:0] operand;
   logic [CNT_W-1:0] result;
   logic             carry_out;

   // two-way operand select
   assign operand = ctrl.pick_cap ? CAP_V : ONE_V;

   lot_occ_addsub #(.WIDTH(CNT_W)) u_addsub (
      .a    (total),
      .b    (operand),
      .sub  (ctrl.subtract),
      .sum  (result),
      .cout (carry_out)
   );

   // zero flag on the adder result
   assign res_zero   = ~|result;
   // no carry out of a subtraction means the operand exceeded the count
   assign res_borrow = ctrl.subtract & ~carry_out;

   // count register: load enable only, deliberately no clear
   always_ff @(posedge clk) begin
      if (ctrl.load) begin
         total <= result;
      end
   end

endmodule

// File: rtl/lot_occ_sequencer.sv
module lot_occ_sequencer (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    enter_req,
   input  logic                    exit_req,
   input  logic                    res_zero,
   input  logic                    res_borrow,
   output lot_occ_pkg::occ_ctrl_t  ctrl,
   output lot_occ_pkg::occ_state_e state,
   output logic                    enter_done,
   output logic                    exit_done,
   output logic                    lot_full
);

   import lot_occ_pkg::*;

   occ_state_e state_q;
   occ_state_e state_d;

   always_comb begin
      ctrl    = '{load: 1'b0, pick_cap: 1'b0, subtract: 1'b0};
      state_d = state_q;
      case (state_q)
         ST_IDLE: begin
            // exit wins over entry; the flags are not consulted here
            if (exit_req) begin
               state_d = ST_DECR;
            end else if (enter_req) begin
               state_d = ST_INCR;
            end
         end
         ST_INCR: begin
            ctrl.load = 1'b1;
            state_d   = ST_CHECK;
         end
         ST_CHECK: begin
            // count minus capacity, register frozen
            ctrl.pick_cap = 1'b1;
            ctrl.subtract = 1'b1;
            state_d       = res_zero ? ST_FULL : ST_IDLE;
         end
         ST_FULL: begin
            if (exit_req) begin
               state_d = ST_DECR;
            end
         end
         ST_DECR: begin
            ctrl.load     = 1'b1;
            ctrl.subtract = 1'b1;
            state_d       = ST_IDLE;
         end
         ST_CLEAR: begin
            // borrow means the count is already zero: stop without writing
            ctrl.subtract = 1'b1;
            ctrl.load     = ~res_borrow;
            if (res_borrow || res_zero) begin
               state_d = ST_IDLE;
            end
         end
         default: begin
            state_d = ST_CLEAR;
         end
      endcase
      if (rst) begin
         state_d = ST_CLEAR;
      end
   end

   always_ff @(posedge clk) begin
      state_q <= state_d;
   end

   assign state      = state_q;
   assign enter_done = (state_q == ST_INCR) & ~rst;
   assign exit_done  = (state_q == ST_DECR) & ~rst;
   assign lot_full   = (state_q == ST_FULL);

endmodule

// File: rtl/lot_occ_ctrl.sv
module lot_occ_ctrl #(
   parameter int  CAPACITY = 6,
   localparam int CNT_W    = $clog2(CAPACITY + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             enter_req,
   input  logic             exit_req,
   output logic             enter_done,
   output logic             exit_done,
   output logic             lot_full,
   output logic [CNT_W-1:0] occupancy
);

   import lot_occ_pkg::*;

   if (CAPACITY < 1) begin : g_cap_bad
      $error("lot_occ_ctrl: CAPACITY must be at least 1");
   end

   occ_ctrl_t  dp_ctrl;
   occ_state_e cur_state;
   logic       res_zero;
   logic       res_borrow;

   lot_occ_datapath #(
      .CAPACITY (CAPACITY),
      .CNT_W    (CNT_W)
   ) u_dp (
      .clk        (clk),
      .ctrl       (dp_ctrl),
      .total      (occupancy),
      .res_zero   (res_zero),
      .res_borrow (res_borrow)
   );

   lot_occ_sequencer u_seq (
      .clk        (clk),
      .rst        (rst),
      .enter_req  (enter_req),
      .exit_req   (exit_req),
      .res_zero   (res_zero),
      .res_borrow (res_borrow),
      .ctrl       (dp_ctrl),
      .state      (cur_state),
      .enter_done (enter_done),
      .exit_done  (exit_done),
      .lot_full   (lot_full)
   );

endmodule

// File: rtl/lot_occ_chk.sv
module lot_occ_chk #(
   parameter int CAPACITY = 6,
   parameter int CNT_W    = 3
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    enter_done,
   input logic                    exit_done,
   input logic                    lot_full,
   input logic [CNT_W-1:0]        occupancy,
   input lot_occ_pkg::occ_state_e state
);

   import lot_occ_pkg::*;

   localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);
   localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

   AST_ENTRY_STEP: assert property (@(posedge clk) disable iff (rst)
      enter_done |=> occupancy == $past(occupancy) + ONE_V); // R1

   AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(enter_done && exit_done)); // R2

   AST_FULL_AT_CAPACITY: assert property (@(posedge clk) disable iff (rst)
      lot_full |-> occupancy == CAP_V); // R3

   AST_FULL_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (rst)
      lot_full |=> !enter_done); // R4

   AST_EXIT_STEP: assert property (@(posedge clk) disable iff (rst)
      exit_done |=> occupancy == $past(occupancy) - ONE_V); // R5

   always @(negedge clk) begin
      if (rst === 1'b1) begin
         AST_RESET_QUIET: assert (!enter_done && !exit_done); // R6
      end
   end

   AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
      (state == ST_CLEAR && occupancy != '0) |=> occupancy == $past(occupancy) - ONE_V); // R7

   AST_BAD_CODE_RECOVER: assert property (@(posedge clk) disable iff (rst)
      (state == occ_state_e'(3'b011) || state == occ_state_e'(3'b110)) |=> state == ST_CLEAR); // R7

   AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
      (state == ST_CLEAR && occupancy == '0) |=> (occupancy == '0 && state != ST_CLEAR)); // R8

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
      (state == ST_IDLE || state == ST_CHECK || state == ST_FULL) |=> $stable(occupancy)); // R9

endmodule

bind lot_occ_ctrl lot_occ_chk #(
   .CAPACITY (CAPACITY),
   .CNT_W    (CNT_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .enter_done (enter_done),
   .exit_done  (exit_done),
   .lot_full   (lot_full),
   .occupancy  (occupancy),
   .state      (cur_state)
);

// File: tb/lot_occ_ctrl_tb_top.sv
`timescale 1ns/1ps
module lot_occ_ctrl_tb_top;

   localparam int CAP   = 6;
   localparam int W     = $clog2(CAP + 1);
   localparam int LIMIT = 20000;

   // reference model phases
   localparam int M_IDLE = 0;
   localparam int M_INC  = 1;
   localparam int M_CMP  = 2;
   localparam int M_FULL = 3;
   localparam int M_DEC  = 4;
   localparam int M_CLR  = 5;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         enter_req = 1'b0;
   logic         exit_req  = 1'b0;
   logic         enter_done;
   logic         exit_done;
   logic         lot_full;
   logic [W-1:0] occupancy;

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cycles = 0;
   string phase = "R6";
   bit    finished = 1'b0;

   int m_state   = M_CLR;
   int m_total   = 0;
   bit m_known   = 1'b0;
   bit m_started = 1'b0;
   int m_clr_cnt = 0;

   always #2 clk = ~clk;

   lot_occ_ctrl #(.CAPACITY(CAP)) dut_i (
      .clk        (clk),
      .rst        (rst),
      .enter_req  (enter_req),
      .exit_req   (exit_req),
      .enter_done (enter_done),
      .exit_done  (exit_done),
      .lot_full   (lot_full),
      .occupancy  (occupancy)
   );

   // behavioural reference, advanced at each rising edge
   always @(posedge clk) begin
      int nxt;
      cycles++;
      nxt = m_state;
      case (m_state)
         M_IDLE: nxt = exit_req ? M_DEC : (enter_req ? M_INC : M_IDLE);
         M_INC: begin m_total = m_total + 1; nxt = M_CMP; end
         M_CMP: nxt = (m_total == CAP) ? M_FULL : M_IDLE;
         M_FULL: nxt = exit_req ? M_DEC : M_FULL;
         M_DEC: begin m_total = m_total - 1; nxt = M_IDLE; end
         default: begin
            if (!m_known) begin
               m_clr_cnt++;
               if (m_clr_cnt >= (1 << W) + 2) begin
                  m_known = 1'b1;
                  m_total = 0;
               end
            end else if (m_total == 0) begin
               nxt = M_IDLE;
            end else begin
               m_total = m_total - 1;
               nxt = (m_total == 0) ? M_IDLE : M_CLR;
            end
         end
      endcase
      if (rst) nxt = M_CLR;
      m_state   = nxt;
      m_started = 1'b1;
   end

   task automatic check_bit(input string what, input logic act, input logic exp, inout bit bad);
      if (act !== exp) begin
         $display("FAIL %s %s actual %0b expected %0b at cycle %0d", phase, what, act, exp, cycles);
         bad = 1'b1;
      end
   endtask

   // compare against the model every cycle, away from the edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (m_started && !finished) begin
            bit bad;
            bad = 1'b0;
            n_cmp++;
            check_bit("enter_done", enter_done, (m_state == M_INC) && !rst, bad);
            check_bit("exit_done",  exit_done,  (m_state == M_DEC) && !rst, bad);
            check_bit("lot_full",   lot_full,   m_state == M_FULL, bad);
            if (m_known && (occupancy !== W'(m_total))) begin
               $display("FAIL %s occupancy actual %0d expected %0d at cycle %0d", phase, occupancy, m_total, cycles);
               bad = 1'b1;
            end
            if (bad) n_bad++;
         end
      end
   end

   task automatic direct(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s directed actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         enter_req = 1'b0;
         exit_req  = 1'b0;
      end
   endtask

   task automatic serve(input bit want_in, input bit want_out);
      @(negedge clk);
      enter_req = want_in;
      exit_req  = want_out;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (enter_done || exit_done) begin
            enter_req = 1'b0;
            exit_req  = 1'b0;
            break;
         end
      end
      enter_req = 1'b0;
      exit_req  = 1'b0;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      @(posedge clk);
      while (cycles < LIMIT) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      finish_run();
   end

   initial begin
      // R6: long reset, count settles at zero
      phase = "R6";
      repeat (14) @(negedge clk);
      #1;
      direct("R6", int'(occupancy), 0);
      direct("R6", int'(enter_done | exit_done | lot_full), 0);
      rst = 1'b0;
      idle(4);

      phase = "R9";
      idle(5);
      #1;
      direct("R9", int'(occupancy), 0);

      phase = "R1";
      serve(1'b1, 1'b0);
      idle(2);
      serve(1'b1, 1'b0);
      idle(1);
      serve(1'b1, 1'b0);
      idle(3);
      #1;
      direct("R1", int'(occupancy), 3);
      serve(1'b0, 1'b1);
      idle(3);
      #1;
      direct("R1", int'(occupancy), 2);

      phase = "R2";
      serve(1'b1, 1'b1);
      idle(3);
      #1;
      direct("R2", int'(occupancy), 1);

      phase = "R3";
      for (int k = 0; k < CAP - 1; k++) begin
         serve(1'b1, 1'b0);
         idle(1);
      end
      idle(2);
      #1;
      direct("R3", int'(lot_full), 1);
      direct("R3", int'(occupancy), CAP);

      phase = "R4";
      @(negedge clk);
      enter_req = 1'b1;
      repeat (6) @(negedge clk);
      #1;
      direct("R4", int'(occupancy), CAP);
      direct("R4", int'(lot_full), 1);
      enter_req = 1'b0;

      phase = "R5";
      serve(1'b0, 1'b1);
      #1;
      direct("R5", int'(lot_full), 0);
      idle(3);
      #1;
      direct("R5", int'(occupancy), CAP - 1);

      phase = "R3";
      serve(1'b1, 1'b0);
      idle(4);
      #1;
      direct("R3", int'(lot_full), 1);

      phase = "R7";
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      idle(CAP + 3);
      #1;
      direct("R7", int'(occupancy), 0);
      direct("R7", int'(lot_full), 0);

      phase = "R8";
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      idle(4);
      #1;
      direct("R8", int'(occupancy), 0);
      serve(1'b1, 1'b0);
      idle(3);
      #1;
      direct("R8", int'(occupancy), 1);

      idle(3);
      finish_run();
   end

endmodule